// File: doc/BRIEF.md
# Status-Modified Interrupt Vector

This block supplies the byte a processor receives when it reads the interrupt vector register of a two-channel serial controller. Software writes an 8-bit base vector. A separate control write sets or clears a single enable. When the enable is clear, a read returns the base vector unchanged. When it is set, vector bits 3:1 are replaced by a three-bit cause code. That code names the most urgent interrupt condition pending across both channels at the clock edge where the read strobe is sampled.

Each channel presents four pending flags. The block ranks the eight flags in a fixed order and encodes the winner. If no flag is pending, it substitutes a fixed idle code. The vector can be read only through channel B. A strobe addressed to channel A leaves the output untouched. The returned byte is captured in a register on the strobe edge, so flags that move later in the read cycle cannot disturb it.

Top module: `intvec_unit`

## Requirements
- R1: After reset, `rd_data` is 0x00, `rd_valid` is 0, the base vector is 0x00 and the enable is clear.
- R2: A write with `wr_en`=1 and `wr_addr`=0 loads `wr_data` into the base vector.
- R3: A write with `wr_en`=1 and `wr_addr`=1 loads `wr_data[0]` into the enable; bits 7:1 of that write have no effect on later reads.
- R4: With the enable clear, a channel B read returns the base vector unmodified, whatever flags are pending.
- R5: With the enable set, bits 7:4 and bit 0 of the returned byte equal the base vector.
- R6: With the enable set, bits 3:1 carry the cause code of the winning flag. Flag positions in each 4-bit pending input are: bit 0 transmit empty, bit 1 external/status, bit 2 receive character, bit 3 special receive. The codes are: A special 111, A receive 110, A ext/status 101, A transmit 100, B special 011, B receive 010, B ext/status 001, B transmit 000.
- R7: Priority from highest to lowest is: A special, A receive, A transmit, A ext/status, then B special, B receive, B transmit, B ext/status.
- R8: With the enable set and no flag pending, bits 3:1 are 011.
- R9: The returned byte reflects the flags and registers at the strobe edge, and `rd_data` holds that value until the next channel B read.
- R10: A strobe with `rd_chan_b`=0 leaves `rd_valid` at 0 and leaves `rd_data` unchanged.
- R11: When a base write and a read fall on the same edge, the read returns the base value held before that write; later reads see the new value.
- R12: `rd_valid` is 1 in exactly the cycle after each edge that samples a channel B strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = base vector, 1 = control (bit 0 enable) |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Vector read strobe |
| rd_chan_b | input | 1 | 1 = read addressed to channel B |
| pend_a | input | 4 | Channel A pending flags |
| pend_b | input | 4 | Channel B pending flags |
| rd_data | output | 8 | Captured vector byte |
| rd_valid | output | 1 | Pulses for one cycle when rd_data is freshly captured |

## Verification
Two functions can fall on the same edge: a base vector write and a channel B read, and flag changes alongside a read. The bench provokes the first with a directed case and also lets random stimulus place writes and reads together. For those cases the bench model takes the expected byte from its base copy before applying the write. The bench checks the second by changing the flags in the cycle after a strobe and confirming that `rd_data` still holds the byte sampled at the strobe edge.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int CODE_W    = 3;

  // positions of each condition inside a channel's pending nibble
  localparam int FLG_TX  = 0;
  localparam int FLG_EXT = 1;
  localparam int FLG_RX  = 2;
  localparam int FLG_SPC = 3;

  typedef enum logic [1:0] {
    CAUSE_TX  = 2'b00,
    CAUSE_EXT = 2'b01,
    CAUSE_RX  = 2'b10,
    CAUSE_SPC = 2'b11
  } cause_e;

  localparam logic [CODE_W-1:0] IDLE_CODE = 3'b011;
endpackage

// File: rtl/intvec_regs.sv
module intvec_regs #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [VEC_W-1:0] wr_data,
  output logic [VEC_W-1:0] base_q,
  output logic             sav_q
);
  logic [VEC_W-1:0] base_d;
  logic             sav_d;
  logic             base_we;
  logic             ctrl_we;

  always_comb begin
    base_we = wr_en && !wr_addr;
    ctrl_we = wr_en &&  wr_addr;
    base_d  = base_we ? wr_data    : base_q;
    sav_d   = ctrl_we ? wr_data[0] : sav_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sav_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      sav_q  <= sav_d;
    end
  end
endmodule

// File: rtl/intvec_chan_prio.sv
module intvec_chan_prio
  import intvec_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] pend,
  output logic                 hit,
  output cause_e               cause
);
  always_comb begin
    hit   = |pend;
    cause = CAUSE_EXT;
    if (pend[FLG_SPC])      cause = CAUSE_SPC;
    else if (pend[FLG_RX])  cause = CAUSE_RX;
    else if (pend[FLG_TX])  cause = CAUSE_TX;
    else if (pend[FLG_EXT]) cause = CAUSE_EXT;
  end
endmodule

// File: rtl/intvec_prio.sv
module intvec_prio
  import intvec_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] pend_a,
  input  logic [NUM_FLAGS-1:0] pend_b,
  output logic [CODE_W-1:0]    code
);
  localparam int NUM_CH = 2;

  logic [NUM_CH*NUM_FLAGS-1:0] pend_all;
  logic [NUM_CH-1:0]           ch_hit;
  cause_e                      ch_cause [NUM_CH];

  // slot 0 is the higher-priority channel (A)
  assign pend_all = {pend_b, pend_a};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    intvec_chan_prio u_chan (
      .pend  (pend_all[ch*NUM_FLAGS +: NUM_FLAGS]),
      .hit   (ch_hit[ch]),
      .cause (ch_cause[ch])
    );
  end

  always_comb begin
    code = IDLE_CODE;
    for (int ch = NUM_CH-1; ch >= 0; ch--) begin
      if (ch_hit[ch]) code = {(ch == 0), ch_cause[ch]};
    end
  end
endmodule

// File: rtl/intvec_read.sv
module intvec_read
  import intvec_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              rd_chan_b,
  input  logic              sav,
  input  logic [VEC_W-1:0]  base,
  input  logic [CODE_W-1:0] code,
  output logic [VEC_W-1:0]  rd_data,
  output logic              rd_valid
);
  localparam int CODE_LO = 1;
  localparam int CODE_HI = CODE_LO + CODE_W - 1;

  logic [VEC_W-1:0] vec_sel;
  logic [VEC_W-1:0] data_d;
  logic             capture;

  always_comb begin
    vec_sel = base;
    if (sav) vec_sel[CODE_HI:CODE_LO] = code;
    capture = rd_stb && rd_chan_b;
    data_d  = capture ? vec_sel : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= data_d;
      rd_valid <= capture;
    end
  end
endmodule

// File: rtl/intvec_unit.sv
module intvec_unit
  import intvec_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [VEC_W-1:0]     wr_data,
  input  logic                 rd_stb,
  input  logic                 rd_chan_b,
  input  logic [NUM_FLAGS-1:0] pend_a,
  input  logic [NUM_FLAGS-1:0] pend_b,
  output logic [VEC_W-1:0]     rd_data,
  output logic                 rd_valid
);
  logic [VEC_W-1:0]  base_q;
  logic              sav_q;
  logic [CODE_W-1:0] cause_code;

  intvec_regs #(.VEC_W(VEC_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .base_q  (base_q),
    .sav_q   (sav_q)
  );

  intvec_prio u_prio (
    .pend_a (pend_a),
    .pend_b (pend_b),
    .code   (cause_code)
  );

  intvec_read #(.VEC_W(VEC_W)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .rd_chan_b (rd_chan_b),
    .sav       (sav_q),
    .base      (base_q),
    .code      (cause_code),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/intvec_chk.sv
module intvec_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [VEC_W-1:0] wr_data,
  input logic             rd_stb,
  input logic             rd_chan_b,
  input logic [3:0]       pend_a,
  input logic [3:0]       pend_b,
  input logic [VEC_W-1:0] rd_data,
  input logic             rd_valid,
  input logic [VEC_W-1:0] base_q,
  input logic             sav_q
);
  assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en && !wr_addr) |-> base_q == $past(wr_data));

  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en && wr_addr) |-> sav_q == $past(wr_data[0]));

  assert_plain_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !$past(sav_q) |-> rd_data == $past(base_q));

  assert_kept_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(sav_q) |->
      rd_data[VEC_W-1:4] == $past(base_q[VEC_W-1:4]) && rd_data[0] == $past(base_q[0]));

  assert_top_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(sav_q) && $past(pend_a[3]) |-> rd_data[3:1] == 3'b111);

  assert_idle_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(sav_q) && $past(pend_a == 4'b0 && pend_b == 4'b0) |->
      rd_data[3:1] == 3'b011);

  assert_chan_a_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !rd_chan_b |=> !rd_valid && $stable(rd_data));

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && rd_chan_b |=> rd_valid);

  assert_valid_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_stb && rd_chan_b));
endmodule

bind intvec_unit intvec_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_stb    (rd_stb),
  .rd_chan_b (rd_chan_b),
  .pend_a    (pend_a),
  .pend_b    (pend_b),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .base_q    (base_q),
  .sav_q     (sav_q)
);

// File: tb/tb_intvec_unit.sv
`timescale 1ns/1ps
module tb_intvec_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_addr;
  logic [7:0] wr_data;
  logic       rd_stb, rd_chan_b;
  logic [3:0] pend_a, pend_b;
  logic [7:0] rd_data;
  logic       rd_valid;

  int nchk  = 0;
  int nfail = 0;

  logic [7:0] base_m;
  logic       sav_m;
  logic [7:0] last_m;

  always #2 clk = ~clk;

  intvec_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_chan_b(rd_chan_b), .pend_a(pend_a), .pend_b(pend_b),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [2:0] cause_of(input logic [3:0] pa, input logic [3:0] pb);
    if (pa[3])      return 3'b111;
    else if (pa[2]) return 3'b110;
    else if (pa[0]) return 3'b100;
    else if (pa[1]) return 3'b101;
    else if (pb[3]) return 3'b011;
    else if (pb[2]) return 3'b010;
    else if (pb[0]) return 3'b000;
    else if (pb[1]) return 3'b001;
    return 3'b011;
  endfunction

  function automatic logic [7:0] expect_vec(input logic [7:0] b, input logic s,
                                            input logic [3:0] pa, input logic [3:0] pb);
    if (!s) return b;
    return {b[7:4], cause_of(pa, pb), b[0]};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle(input string req, input logic we, input logic wa, input logic [7:0] wd,
                       input logic rs, input logic rb, input logic [3:0] pa, input logic [3:0] pb);
    logic       exp_v;
    logic [7:0] exp_d;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_stb = rs; rd_chan_b = rb; pend_a = pa; pend_b = pb;
    exp_v = rs && rb;
    exp_d = exp_v ? expect_vec(base_m, sav_m, pa, pb) : last_m;
    @(posedge clk);
    #1;
    check(req, "rd_valid", int'(rd_valid), int'(exp_v));
    check(req, "rd_data", int'(rd_data), int'(exp_d));
    last_m = exp_d;
    if (we) begin
      if (wa) sav_m = wd[0];
      else    base_m = wd;
    end
  endtask

  task automatic idle(input string req, input logic [3:0] pa, input logic [3:0] pb);
    cycle(req, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, pa, pb);
  endtask

  task automatic rd_b(input string req, input logic [3:0] pa, input logic [3:0] pb);
    cycle(req, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, pa, pb);
  endtask

  task automatic wr(input string req, input logic wa, input logic [7:0] wd);
    cycle(req, 1'b1, wa, wd, 1'b0, 1'b0, 4'h0, 4'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0;
    rd_stb = 0; rd_chan_b = 0; pend_a = 0; pend_b = 0;
    base_m = 8'h00; sav_m = 1'b0; last_m = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rd_data at reset", int'(rd_data), 0);
    check("R1", "rd_valid at reset", int'(rd_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: base reset to zero and enable clear, even with flags pending
    rd_b("R1", 4'hF, 4'hF);
    // R12: valid drops after a single read
    idle("R12", 4'h0, 4'h0);

    // R2 and R4: load base, read unmodified with flags pending
    wr("R2", 1'b0, 8'hA5);
    rd_b("R4", 4'hF, 4'h3);
    // R3: control write with bit 0 clear keeps vector plain
    wr("R3", 1'b1, 8'hFE);
    rd_b("R3", 4'h8, 4'h0);
    // R8: enable on, nothing pending, expect 0xA7
    wr("R3", 1'b1, 8'h01);
    rd_b("R8", 4'h0, 4'h0);
    check("R8", "idle byte", int'(last_m), 8'hA7);

    // R6: each flag alone
    for (int i = 0; i < 4; i++) rd_b("R6", 4'(1 << i), 4'h0);
    for (int i = 0; i < 4; i++) rd_b("R6", 4'h0, 4'(1 << i));
    // R7: priority among several pending
    rd_b("R7", 4'hF, 4'hF);
    rd_b("R7", 4'h3, 4'hF);
    check("R7", "tx over ext", int'(last_m[3:1]), 3'b100);
    rd_b("R7", 4'h0, 4'h6);
    rd_b("R7", 4'h0, 4'h3);
    check("R7", "B tx over ext", int'(last_m[3:1]), 3'b000);

    // R5: different base, kept bits
    wr("R2", 1'b0, 8'h5A);
    rd_b("R5", 4'h2, 4'h0);
    check("R5", "kept bits", int'(last_m), 8'h5A);

    // R9: flags change after strobe, data holds
    rd_b("R9", 4'h8, 4'h0);
    idle("R9", 4'h0, 4'hF);
    idle("R9", 4'h4, 4'h1);

    // R10: channel A read leaves output alone
    cycle("R10", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'h1, 4'h0);
    cycle("R10", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'h0, 4'h0);

    // R11: write and read on the same edge
    wr("R3", 1'b1, 8'h00);
    cycle("R11", 1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, 4'h0, 4'h0);
    check("R11", "old base returned", int'(last_m), 8'h5A);
    rd_b("R11", 4'h0, 4'h0);
    check("R11", "new base seen", int'(last_m), 8'h3C);

    // R12: back-to-back reads each valid
    rd_b("R12", 4'h1, 4'h0);
    rd_b("R12", 4'h0, 4'h2);

    // random mix
    for (int n = 0; n < 500; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cycle("R6", r[0] & r[1], r[2], 8'($urandom), r[3] | r[4], r[5] | r[6],
            4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom));
    end

    finish_run();
  end
endmodule